// File: doc/BRIEF.md
# Single-Channel Byte DMA Controller

This block is one DMA channel. It copies bytes between a 24-bit memory-side address and a small window of peripheral registers. Software programs seven byte-wide registers: control, peripheral port, the three bytes of the memory address and the two bytes of the byte count. A start pulse then launches the transfer. For each byte the engine performs at most one read and one write on a single request/ready bus master port. It rotates the peripheral address through a pattern chosen by the transfer mode, and it steps the memory address and the count.

One peripheral port (0x80, the work-RAM data port) gets special handling when the memory address also decodes to work RAM. The decode comes in on `a_is_wram_i`. Memory-to-port bytes are then skipped, but they are still charged the full byte cost. Port-to-memory bytes skip the read, write 0xFF and are charged half the byte cost. At the end the engine raises a one-cycle done pulse and presents the total number of master cycles the transfer consumed.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, all seven registers read 0. Register offsets are 0 control, 1 port, 2 memory address bits 7:0, 3 bits 15:8, 4 bits 23:16, 5 count bits 7:0 and 6 count bits 15:8. Each register can be written and reads back on `reg_rdata_o` combinationally.
- R2: A read or write at an offset above 6 drives `reg_err_o` high in the same cycle. Such a write changes no register.
- R3: Register writes issued while `busy_o` is high are ignored.
- R4: Control byte: bits 2:0 mode, bit 3 down-step, bit 4 hold address, bit 7 direction. Direction 0 reads the memory address and writes the peripheral address. Direction 1 reads the peripheral address and writes the memory address.
- R5: The peripheral address of byte i is 0x00_2100 OR the 9-bit sum (port + offset(i)), where i counts from 0.
- R6: offset(i) is 0 for modes 0, 2 and 6; i mod 2 for modes 1 and 5; 1 for modes 3 and 7 when (i mod 4) is 2 or 3, otherwise 0; i mod 4 for mode 4.
- R7: After each byte, bits 15:0 of the memory address wrap-decrement by 1 if bit 3 is set and wrap-increment by 1 otherwise. They stay unchanged if bit 4 is set. Bits 23:16 never change.
- R8: The count decrements after each byte, and the engine continues while the new count is nonzero, so a start count of 0 means 65536 bytes.
- R9: `cycles_o` is 8 plus 8 for every normally transferred byte.
- R10: With port 0x80, `a_is_wram_i` high and direction 0, a byte makes no bus access and costs 8 cycles.
- R11: With port 0x80, `a_is_wram_i` high and direction 1, a byte makes no read, writes 0xFF to the memory address and costs 4 cycles.
- R12: A pulse on `stop_i` during a transfer ends it after the byte in progress.
- R13: `done_o` pulses for exactly one cycle with `busy_o` low, and `cycles_o` holds the total from then on. A request keeps its address, direction and data until `m_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (used for error flag) |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| reg_err_o | output | 1 | Access to an undefined offset |
| start_i | input | 1 | Launch a transfer when idle |
| stop_i | input | 1 | End the transfer after the current byte |
| a_is_wram_i | input | 1 | Current memory address decodes to work RAM |
| m_req_o | output | 1 | Bus request |
| m_we_o | output | 1 | Bus write (1) or read (0) |
| m_addr_o | output | 24 | Bus address |
| m_wdata_o | output | 8 | Bus write data |
| m_ready_i | input | 1 | Bus accepts the request this cycle |
| m_rdata_i | input | 8 | Bus read data, valid with ready on reads |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| cycles_o | output | 32 | Master cycles consumed by the last transfer |

## Verification
Register reads and the error flag are combinational, so the bench samples them one time step after it drives the offset in the same cycle. Bus transactions are logged on the clock edge where request and ready are both high. The bench compares that log, in order, against a bench model of the transfer, so random ready stalls cannot shift any expectation. `done_o` rises in the cycle after the last byte's step. The bench counts done edges and reads `cycles_o` and the stepped address and count registers after that edge, because all three hold until the next start. A stop pulse is driven in the cycle right after the chosen byte's write handshake, which is the step cycle of that byte.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    M_ONE           = 3'd0,
    M_PAIR          = 3'd1,
    M_TWO_ONE       = 3'd2,
    M_QUAD_PAIR     = 3'd3,
    M_QUAD          = 3'd4,
    M_PAIR_ALT      = 3'd5,
    M_TWO_ONE_ALT   = 3'd6,
    M_QUAD_PAIR_ALT = 3'd7
  } xfer_mode_e;

  typedef struct packed {
    logic       to_mem;   // 1: peripheral -> memory
    logic [1:0] spare;
    logic       hold;     // memory address fixed
    logic       down;     // memory address decrements
    xfer_mode_e mode;
  } ctrl_t;

  localparam int REG_CTRL   = 0;
  localparam int REG_PORT   = 1;
  localparam int REG_A_LO   = 2;
  localparam int REG_A_MID  = 3;
  localparam int REG_A_BANK = 4;
  localparam int REG_CNT_LO = 5;
  localparam int REG_CNT_HI = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_READ,
    ST_WRITE,
    ST_STEP
  } fsm_e;

endpackage

// File: rtl/dma_b_offset.sv
module dma_b_offset
  import dma_chan_pkg::*;
(
  input  xfer_mode_e mode_i,
  input  logic [1:0] idx_i,
  output logic [1:0] off_o
);

  always_comb begin
    unique case (mode_i)
      M_PAIR, M_PAIR_ALT:           off_o = {1'b0, idx_i[0]};
      M_QUAD_PAIR, M_QUAD_PAIR_ALT: off_o = {1'b0, idx_i[1]};
      M_QUAD:                       off_o = idx_i;
      default:                      off_o = 2'd0;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              err_o,
  input  logic              lock_i,
  input  logic              step_i,
  output xfer_mode_e        mode_o,
  output logic              to_mem_o,
  output logic [7:0]        port_o,
  output logic [ADDR_W-1:0] a_addr_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam int unsigned STEP_W = 16;

  ctrl_t             ctrl_q;
  logic [7:0]        port_q;
  logic [ADDR_W-1:0] a_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid;

  assign valid = (addr_i <= AW'(REG_CNT_HI));
  assign err_o = (we_i | re_i) & ~valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      port_q <= '0;
      a_q    <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      if (!ctrl_q.hold)
        a_q[STEP_W-1:0] <= ctrl_q.down ? a_q[STEP_W-1:0] - 1'b1
                                       : a_q[STEP_W-1:0] + 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end else if (we_i && !lock_i && valid) begin
      unique case (addr_i)
        AW'(REG_CTRL):   ctrl_q      <= ctrl_t'(wdata_i);
        AW'(REG_PORT):   port_q      <= wdata_i;
        AW'(REG_A_LO):   a_q[7:0]    <= wdata_i;
        AW'(REG_A_MID):  a_q[15:8]   <= wdata_i;
        AW'(REG_A_BANK): a_q[23:16]  <= wdata_i;
        AW'(REG_CNT_LO): cnt_q[7:0]  <= wdata_i;
        AW'(REG_CNT_HI): cnt_q[15:8] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      AW'(REG_CTRL):   rdata_o = ctrl_q;
      AW'(REG_PORT):   rdata_o = port_q;
      AW'(REG_A_LO):   rdata_o = a_q[7:0];
      AW'(REG_A_MID):  rdata_o = a_q[15:8];
      AW'(REG_A_BANK): rdata_o = a_q[23:16];
      AW'(REG_CNT_LO): rdata_o = cnt_q[7:0];
      AW'(REG_CNT_HI): rdata_o = cnt_q[15:8];
      default:         rdata_o = 8'h00;
    endcase
  end

  assign mode_o   = ctrl_q.mode;
  assign to_mem_o = ctrl_q.to_mem;
  assign port_o   = port_q;
  assign a_addr_o = a_q;
  assign count_o  = cnt_q;

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CYC_W     = 32,
  parameter int unsigned OVERHEAD  = 8,
  parameter int unsigned BYTE_COST = 8,
  parameter int unsigned WRAM_COST = 4,
  parameter logic [7:0]  WRAM_PORT = 8'h80,
  parameter logic [15:0] B_BASE    = 16'h2100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  xfer_mode_e        mode_i,
  input  logic              to_mem_i,
  input  logic [7:0]        port_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              a_is_wram_i,
  output logic              m_req_o,
  output logic              m_we_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [7:0]        m_wdata_o,
  input  logic              m_ready_i,
  input  logic [7:0]        m_rdata_i,
  output logic              step_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CYC_W-1:0]  cycles_o
);

  localparam int unsigned COST_W = 8;

  fsm_e              state_q, state_d;
  logic              en_q;
  logic [1:0]        idx_q;
  logic [7:0]        data_q;
  logic [COST_W-1:0] cost_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              done_q;
  logic [1:0]        off;
  logic [8:0]        b_sum;
  logic [ADDR_W-1:0] b_addr, src_addr, dst_addr;
  logic              wram_hit, last_byte;

  dma_b_offset u_off (
    .mode_i (mode_i),
    .idx_i  (idx_q),
    .off_o  (off)
  );

  // 9-bit sum: a carry out of the port byte reaches bit 8
  assign b_sum    = {1'b0, port_i} + {7'd0, off};
  assign b_addr   = {{(ADDR_W-16){1'b0}}, B_BASE | {7'd0, b_sum}};
  assign src_addr = to_mem_i ? b_addr : a_addr_i;
  assign dst_addr = to_mem_i ? a_addr_i : b_addr;
  assign wram_hit = (port_i == WRAM_PORT) && a_is_wram_i;
  assign last_byte = (count_i == CNT_W'(1)) || !en_q || stop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i && !stop_i) state_d = ST_EVAL;
      ST_EVAL: begin
        if (wram_hit && !to_mem_i)     state_d = ST_STEP;
        else if (wram_hit && to_mem_i) state_d = ST_WRITE;
        else                           state_d = ST_READ;
      end
      ST_READ:  if (m_ready_i) state_d = ST_WRITE;
      ST_WRITE: if (m_ready_i) state_d = ST_STEP;
      ST_STEP:  state_d = last_byte ? ST_IDLE : ST_EVAL;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      cost_q  <= '0;
      cyc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (stop_i) en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i && !stop_i) begin
          en_q  <= 1'b1;
          idx_q <= '0;
          cyc_q <= CYC_W'(OVERHEAD);
        end
        ST_EVAL: begin
          if (wram_hit && to_mem_i) begin
            data_q <= 8'hFF;
            cost_q <= COST_W'(WRAM_COST);
          end else begin
            cost_q <= COST_W'(BYTE_COST);
          end
        end
        ST_READ: if (m_ready_i) data_q <= m_rdata_i;
        ST_STEP: begin
          cyc_q <= cyc_q + CYC_W'(cost_q);
          idx_q <= idx_q + 2'd1;
          if (last_byte) begin
            en_q   <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    m_req_o   = 1'b0;
    m_we_o    = 1'b0;
    m_addr_o  = '0;
    m_wdata_o = '0;
    if (state_q == ST_READ) begin
      m_req_o  = 1'b1;
      m_addr_o = src_addr;
    end else if (state_q == ST_WRITE) begin
      m_req_o   = 1'b1;
      m_we_o    = 1'b1;
      m_addr_o  = dst_addr;
      m_wdata_o = data_q;
    end
  end

  assign step_o   = (state_q == ST_STEP);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign cycles_o = cyc_q;

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int unsigned REG_AW    = 4,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CYC_W     = 32,
  parameter int unsigned OVERHEAD  = 8,
  parameter int unsigned BYTE_COST = 8,
  parameter int unsigned WRAM_COST = 4,
  parameter logic [7:0]  WRAM_PORT = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              reg_err_o,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              a_is_wram_i,
  output logic              m_req_o,
  output logic              m_we_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [7:0]        m_wdata_o,
  input  logic              m_ready_i,
  input  logic [7:0]        m_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CYC_W-1:0]  cycles_o
);

  xfer_mode_e        mode;
  logic              to_mem, step;
  logic [7:0]        port;
  logic [ADDR_W-1:0] a_addr;
  logic [CNT_W-1:0]  count;

  dma_chan_regs #(
    .AW     (REG_AW),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .re_i     (reg_re_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .err_o    (reg_err_o),
    .lock_i   (busy_o),
    .step_i   (step),
    .mode_o   (mode),
    .to_mem_o (to_mem),
    .port_o   (port),
    .a_addr_o (a_addr),
    .count_o  (count)
  );

  dma_chan_fsm #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .CYC_W     (CYC_W),
    .OVERHEAD  (OVERHEAD),
    .BYTE_COST (BYTE_COST),
    .WRAM_COST (WRAM_COST),
    .WRAM_PORT (WRAM_PORT)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .mode_i      (mode),
    .to_mem_i    (to_mem),
    .port_i      (port),
    .a_addr_i    (a_addr),
    .count_i     (count),
    .a_is_wram_i (a_is_wram_i),
    .m_req_o     (m_req_o),
    .m_we_o      (m_we_o),
    .m_addr_o    (m_addr_o),
    .m_wdata_o   (m_wdata_o),
    .m_ready_i   (m_ready_i),
    .m_rdata_i   (m_rdata_i),
    .step_o      (step),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cycles_o    (cycles_o)
  );

endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int unsigned REG_AW = 4,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CYC_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_err_o,
  input logic              m_req_o,
  input logic              m_we_o,
  input logic [ADDR_W-1:0] m_addr_o,
  input logic [7:0]        m_wdata_o,
  input logic              m_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [CYC_W-1:0]  cycles_o
);

  // R13
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R13
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_ready_i) |=> (m_req_o && $stable(m_addr_o) &&
                                 $stable(m_we_o) && $stable(m_wdata_o)));

  // R2
  bad_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> ((reg_we_i || reg_re_i) && (int'(reg_addr_i) > 6)));

  // R9
  cyc_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o[1:0] == 2'b00 && cycles_o >= CYC_W'(12)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !m_req_o);

endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(
  .REG_AW (REG_AW),
  .ADDR_W (ADDR_W),
  .CYC_W  (CYC_W)
) u_chk (.*);

// File: tb/dma_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_err;
  logic        start = 1'b0, stop = 1'b0, wram = 1'b0;
  logic        m_req, m_we, m_ready = 1'b0;
  logic [23:0] m_addr;
  logic [7:0]  m_wdata, m_rdata = '0;
  logic        busy, done;
  logic [31:0] cycles;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, done_cnt = 0, done_dbl = 0;
  logic done_prev = 1'b0;

  bit          log_we[$];
  logic [23:0] log_addr[$];
  logic [7:0]  log_data[$];
  bit          exp_we[$];
  logic [23:0] exp_addr[$];
  logic [7:0]  exp_data[$];

  always #2.5 clk = ~clk;

  dma_chan_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_err_o(reg_err),
    .start_i(start), .stop_i(stop), .a_is_wram_i(wram),
    .m_req_o(m_req), .m_we_o(m_we), .m_addr_o(m_addr), .m_wdata_o(m_wdata),
    .m_ready_i(m_ready), .m_rdata_i(m_rdata),
    .busy_o(busy), .done_o(done), .cycles_o(cycles)
  );

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [1:0] mode_off(input logic [2:0] m, input int i);
    case (m)
      3'd1, 3'd5: return 2'(i % 2);
      3'd3, 3'd7: return ((i % 4) > 1) ? 2'd1 : 2'd0;
      3'd4:       return 2'(i % 4);
      default:    return 2'd0;
    endcase
  endfunction

  // bus slave: random stalls, data derived from address
  always @(negedge clk) begin
    m_ready <= m_req && (($urandom % 4) != 0);
    m_rdata <= mem_val(m_addr);
  end

  always @(posedge clk) begin
    if (m_req && m_ready) begin
      log_we.push_back(m_we);
      log_addr.push_back(m_addr);
      log_data.push_back(m_wdata);
      if (m_we) wr_cnt++;
    end
    if (done) done_cnt++;
    if (done && done_prev) done_dbl++;
    done_prev <= done;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [7:0] d, output logic e);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 4'(a);
    #1;
    d = reg_rdata; e = reg_err;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic model(input logic [7:0] ctrl, input logic [7:0] port,
                       input logic [23:0] a_in, input logic [15:0] cnt_in,
                       input bit wr, input int max_b,
                       output int cyc, output logic [23:0] a_end,
                       output logic [15:0] c_end);
    logic [23:0] a, b;
    logic [15:0] c;
    logic [8:0]  s9;
    int i;
    a = a_in; c = cnt_in; i = 0; cyc = 8;
    exp_we.delete(); exp_addr.delete(); exp_data.delete();
    do begin
      s9 = {1'b0, port} + {7'd0, mode_off(ctrl[2:0], i)};
      b  = {8'h00, 16'h2100 | {7'd0, s9}};
      if (port == 8'h80 && wr) begin
        if (ctrl[7]) begin
          exp_we.push_back(1); exp_addr.push_back(a); exp_data.push_back(8'hFF);
          cyc += 4;
        end else cyc += 8;
      end else begin
        if (!ctrl[7]) begin
          exp_we.push_back(0); exp_addr.push_back(a); exp_data.push_back(8'h00);
          exp_we.push_back(1); exp_addr.push_back(b); exp_data.push_back(mem_val(a));
        end else begin
          exp_we.push_back(0); exp_addr.push_back(b); exp_data.push_back(8'h00);
          exp_we.push_back(1); exp_addr.push_back(a); exp_data.push_back(mem_val(b));
        end
        cyc += 8;
      end
      if (!ctrl[4]) a[15:0] = ctrl[3] ? a[15:0] - 16'd1 : a[15:0] + 16'd1;
      c = c - 16'd1;
      i++;
    end while (c != 16'd0 && (max_b == 0 || i < max_b));
    a_end = a; c_end = c;
  endtask

  task automatic run_xfer(input logic [7:0] ctrl, input logic [7:0] port,
                          input logic [23:0] a, input logic [15:0] cnt,
                          input bit wr, input int stop_after, input bit poke,
                          input string tag);
    int cyc, d0, guard;
    logic [23:0] a_end;
    logic [15:0] c_end;
    logic [7:0] r0, r1, r2;
    logic e;
    bit ok;
    reg_wr(0, ctrl); reg_wr(1, port);
    reg_wr(2, a[7:0]); reg_wr(3, a[15:8]); reg_wr(4, a[23:16]);
    reg_wr(5, cnt[7:0]); reg_wr(6, cnt[15:8]);
    model(ctrl, port, a, cnt, wr, stop_after, cyc, a_end, c_end);
    log_we.delete(); log_addr.delete(); log_data.delete();
    wr_cnt = 0;
    wram = wr;
    d0 = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      chk(busy == 1'b1, {tag, " R3 busy before poke"}, busy, 1);
      reg_wr(5, 8'h33); reg_wr(1, 8'h44); reg_wr(0, 8'h00);
    end
    if (stop_after > 0) begin
      guard = 0;
      while (wr_cnt < stop_after && guard < 20000) begin @(negedge clk); guard++; end
      stop = 1'b1;
      @(negedge clk); stop = 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(done_cnt == d0 + 1, {tag, " R13 done seen"}, done_cnt - d0, 1);
    @(negedge clk);
    chk(cycles == 32'(cyc), {tag, " R9 R10 R11 cycles"}, cycles, cyc);
    chk(busy == 1'b0 && done == 1'b0, {tag, " R13 idle after done"}, {busy, done}, 0);
    ok = (log_we.size() == exp_we.size());
    if (ok) foreach (exp_we[k]) begin
      if (log_we[k] != exp_we[k] || log_addr[k] != exp_addr[k] ||
          (exp_we[k] && log_data[k] != exp_data[k])) ok = 0;
    end
    chk(ok, {tag, " R4 R5 R6 bus sequence (size)"}, log_we.size(), exp_we.size());
    reg_rd(2, r0, e); reg_rd(3, r1, e); reg_rd(4, r2, e);
    chk({r2, r1, r0} == a_end, {tag, " R7 final address"}, {r2, r1, r0}, a_end);
    reg_rd(5, r0, e); reg_rd(6, r1, e);
    chk({r1, r0} == c_end, {tag, " R8 final count"}, {r1, r0}, c_end);
    if (poke) begin
      reg_rd(1, r0, e);
      chk(r0 == port, {tag, " R3 port untouched"}, r0, port);
      reg_rd(0, r0, e);
      chk(r0 == ctrl, {tag, " R3 control untouched"}, r0, ctrl);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic e;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 7; a++) begin
      reg_rd(a, d, e);
      chk(d == 8'h00 && !e, "R1 reset value", d, 0);
    end
    chk(!busy && !done && !m_req, "R13 idle after reset", {busy, done, m_req}, 0);

    // R1 read back
    for (int a = 0; a < 7; a++) reg_wr(a, 8'(8'h11 * (a + 1)));
    for (int a = 0; a < 7; a++) begin
      reg_rd(a, d, e);
      chk(d == 8'(8'h11 * (a + 1)), "R1 readback", d, 8'(8'h11 * (a + 1)));
    end

    // R2 undefined offsets
    reg_rd(9, d, e);
    chk(e == 1'b1, "R2 error on read at 9", e, 1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd7; reg_wdata = 8'hEE;
    #1 chk(reg_err == 1'b1, "R2 error on write at 7", reg_err, 1);
    @(negedge clk); reg_we = 1'b0;
    for (int a = 0; a < 7; a++) begin
      reg_rd(a, d, e);
      chk(d == 8'(8'h11 * (a + 1)) && !e, "R2 registers unchanged", d, 8'(8'h11 * (a + 1)));
    end

    // directed transfers
    run_xfer(8'h04, 8'h18, 24'h7E_FFFE, 16'd6, 0, 0, 0, "quad up wrap");
    run_xfer(8'h8B, 8'hFF, 24'h00_0001, 16'd5, 0, 0, 0, "quad-pair down carry");
    run_xfer(8'h11, 8'h04, 24'h12_3456, 16'd4, 0, 0, 0, "pair hold");
    run_xfer(8'h00, 8'h80, 24'h7E_1000, 16'd3, 1, 0, 0, "R10 wram to port");
    run_xfer(8'h80, 8'h80, 24'h7E_2000, 16'd3, 1, 0, 0, "R11 port to wram");
    run_xfer(8'h80, 8'h80, 24'h00_2000, 16'd2, 0, 0, 0, "port 80 not wram");
    run_xfer(8'h04, 8'h30, 24'h01_0000, 16'd0, 0, 5, 0, "R12 R8 stop on zero count");
    run_xfer(8'h05, 8'h10, 24'h02_0000, 16'd10, 0, 0, 1, "R3 writes while busy");

    // random transfers
    for (int n = 0; n < 24; n++) begin
      logic [7:0] c, p;
      logic [23:0] a;
      logic [15:0] cnt;
      bit w;
      c   = 8'($urandom) & 8'h9F;
      p   = (($urandom % 4) == 0) ? 8'h80 : 8'($urandom);
      a   = 24'($urandom);
      if (($urandom % 3) == 0) a[15:0] = 16'hFFFE;
      cnt = 16'(1 + $urandom % 12);
      w   = 1'($urandom);
      run_xfer(c, p, a, cnt, w, 0, 0, "random");
    end

    chk(done_dbl == 0, "R13 done never two cycles", done_dbl, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule